// File: doc/BRIEF.md
# Eight-bit ALU with condition flags

This block is a small arithmetic unit for an accumulator-style datapath. It takes two operands and an operation code, and it produces the result combinationally in the same cycle. From that result and from the operation it derives four condition flags: negative, zero, signed overflow and carry/borrow. The flags are held in a register. That register is written on a clock edge only when the caller asks for it and the operation is one that affects flags. This lets the surrounding sequencer run loads and moves without disturbing a comparison result it still needs.

Subtraction reports a true borrow: the carry flag is set when the unsigned subtrahend is larger than the minuend. Negate, test and clear reuse the subtract path with fixed operands, so all of them follow the same flag rules. Arithmetic shift right has its own short path. The operand width is a parameter with a default of eight bits. A second parameter can switch the subtract carry to the raw adder carry-out for datapaths that expect that convention.

Top module: `nzvc_alu`

## Requirements
- R1: After a flag write, `flag_n` equals the top bit of the result produced in the write cycle, and `flag_z` is 1 exactly when every result bit was 0.
- R2: `op_sel`=0 (add) gives `result`=`op_a`+`op_b` modulo 256. C is set when the unsigned sum exceeds 0xFF. V is set when both operands share a sign and the result has the other sign.
- R3: `op_sel`=1 (subtract) gives `result`=`op_a`-`op_b` modulo 256. C is set when `op_b` > `op_a` as unsigned values. V is set when the operands differ in sign and the result sign differs from `op_a`.
- R4: `op_sel`=2 (negate) gives `result`=0-`op_a`. C is set for any nonzero `op_a`, and V is set only for `op_a`=0x80.
- R5: `op_sel`=3 (test) gives `result`=`op_a`, with V=0 and C=0.
- R6: `op_sel`=4 (clear) gives `result`=0 and writes N=0, Z=1, V=0, C=0.
- R7: `op_sel`=5 (arithmetic shift right) gives `result`={`op_a`[7], `op_a`[7:1]}. C takes the old `op_a`[0], and V=N xor C.
- R8: `op_sel`=6 (load) drives `result`=`op_b`, and `op_sel`=7 (keep) drives `result`=`op_a`. Neither changes the flags, even with `flag_en`=1.
- R9: With `flag_en`=0 the flags keep their values across the clock edge, whatever the operation.
- R10: An active-low `rst_n` clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_a | input | 8 | First operand (minuend, or the value being negated, tested or shifted) |
| op_b | input | 8 | Second operand (addend or subtrahend, or the load value) |
| op_sel | input | 3 | Operation code, encoded as listed in R2 to R8 |
| flag_en | input | 1 | Requests a flag write at the next rising edge |
| result | output | 8 | Combinational result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered signed overflow flag |
| flag_c | output | 1 | Registered carry (add), borrow (subtract) or shifted-out bit |

## Verification
On every flag write, the assertions check that N and Z follow the captured result. They also check the add carry and the subtract borrow against unsigned comparisons of the past operands, the negate carry, the fixed clear pattern and the shift rule V = N xor C. Every cycle with no write must leave the flags stable. The overflow flag for add and subtract, the exact result values and the reset clearing are shown only by the bench. It checks the worked vectors, exhaustive single-operand sweeps, a dense two-operand grid, and sequences that set the flags and then try to disturb them with load, keep, a cleared enable or a reset.

// File: rtl/nzvc_pkg.sv
package nzvc_pkg;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_NEG  = 3'd2,
      OP_TST  = 3'd3,
      OP_CLR  = 3'd4,
      OP_ASR  = 3'd5,
      OP_LOAD = 3'd6,
      OP_KEEP = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;

   localparam ccr_t CCR_RESET = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

   // operations allowed to write the flag register
   function automatic logic op_writes_flags(alu_op_e op);
      return !(op inside {OP_LOAD, OP_KEEP});
   endfunction

   // operations whose result comes from the shared add/subtract path
   function automatic logic op_uses_adder(alu_op_e op);
      return op inside {OP_ADD, OP_SUB, OP_NEG, OP_TST, OP_CLR};
   endfunction

endpackage

// File: rtl/nzvc_addsub.sv
module nzvc_addsub #(
   parameter int WIDTH       = 8,
   parameter bit TRUE_BORROW = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             carry,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("nzvc_addsub: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] y_eff;
   logic [WIDTH:0]   wide;
   logic             cout;

   // subtraction as x + ~y + 1
   assign y_eff = sub ? ~y : y;
   assign wide  = {1'b0, x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, sub};
   assign sum   = wide[MSB:0];
   assign cout  = wide[WIDTH];

   // signed overflow: like-signed inputs to the adder, result of the other sign
   assign ovf = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);

   if (TRUE_BORROW) begin : g_borrow
      assign carry = sub ? ~cout : cout;
   end else begin : g_raw_carry
      assign carry = cout;
   end

endmodule

// File: rtl/nzvc_shifter.sv
module nzvc_shifter #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] x,
   output logic [WIDTH-1:0] res,
   output logic             out_bit
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("nzvc_shifter: WIDTH must be at least 2");
   end

   // sign bit is replicated, lowest bit falls out
   assign res     = {x[MSB], x[MSB:1]};
   assign out_bit = x[0];

endmodule

// File: rtl/nzvc_flag_reg.sv
module nzvc_flag_reg
   import nzvc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  ccr_t d,
   output ccr_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= CCR_RESET;
      end else if (wr) begin
         q <= d;
      end
   end

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q)); // R9

endmodule

// File: rtl/nzvc_alu.sv
module nzvc_alu
   import nzvc_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit TRUE_BORROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [2:0]       op_sel,
   input  logic             flag_en,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_v,
   output logic             flag_c
);
   localparam int               MSB  = WIDTH - 1;
   localparam logic [WIDTH-1:0] ZERO = '0;
   localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

   if (WIDTH < 2) begin : g_bad_width
      $error("nzvc_alu: WIDTH must be at least 2");
   end

   alu_op_e          op;
   logic [WIDTH-1:0] add_x, add_y, add_sum;
   logic             add_sub, add_c, add_v;
   logic [WIDTH-1:0] sh_res;
   logic             sh_out;
   logic             flag_wr;
   ccr_t             ccr_d, ccr_q;

   assign op = alu_op_e'(op_sel);

   // operand steering for the shared add/subtract path
   always_comb begin
      add_x   = op_a;
      add_y   = op_b;
      add_sub = 1'b0;
      unique case (op)
         OP_ADD: begin add_x = op_a; add_y = op_b; add_sub = 1'b0; end
         OP_SUB: begin add_x = op_a; add_y = op_b; add_sub = 1'b1; end
         OP_NEG: begin add_x = ZERO; add_y = op_a; add_sub = 1'b1; end
         OP_TST: begin add_x = op_a; add_y = ZERO; add_sub = 1'b1; end
         OP_CLR: begin add_x = ZERO; add_y = ZERO; add_sub = 1'b1; end
         default: begin add_x = op_a; add_y = op_b; add_sub = 1'b0; end
      endcase
   end

   nzvc_addsub #(
      .WIDTH       (WIDTH),
      .TRUE_BORROW (TRUE_BORROW)
   ) i_addsub (
      .x     (add_x),
      .y     (add_y),
      .sub   (add_sub),
      .sum   (add_sum),
      .carry (add_c),
      .ovf   (add_v)
   );

   nzvc_shifter #(
      .WIDTH (WIDTH)
   ) i_shifter (
      .x       (op_a),
      .res     (sh_res),
      .out_bit (sh_out)
   );

   // result selection
   always_comb begin
      if (op_uses_adder(op)) begin
         result = add_sum;
      end else if (op == OP_ASR) begin
         result = sh_res;
      end else if (op == OP_LOAD) begin
         result = op_b;
      end else begin
         result = op_a;
      end
   end

   // next flag values
   always_comb begin
      ccr_d.n = result[MSB];
      ccr_d.z = (result == ZERO);
      if (op == OP_ASR) begin
         ccr_d.c = sh_out;
         ccr_d.v = sh_res[MSB] ^ sh_out;
      end else begin
         ccr_d.c = add_c;
         ccr_d.v = add_v;
      end
   end

   assign flag_wr = flag_en && op_writes_flags(op);

   nzvc_flag_reg i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (flag_wr),
      .d     (ccr_d),
      .q     (ccr_q)
   );

   assign flag_n = ccr_q.n;
   assign flag_z = ccr_q.z;
   assign flag_v = ccr_q.v;
   assign flag_c = ccr_q.c;

   AST_N_FOLLOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr |=> flag_n == $past(result[MSB])); // R1
   AST_Z_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr |=> flag_z == ($past(result) == ZERO)); // R1
   AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && op == OP_ADD) |=> flag_c == ($past(op_b) > ~$past(op_a))); // R2
   AST_NEG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && op == OP_NEG) |=> flag_c == ($past(op_a) != ZERO)); // R4
   AST_NEG_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && op == OP_NEG) |=> flag_v == ($past(op_a) == MINV)); // R4
   AST_TST_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && op == OP_TST) |=> (!flag_v && !flag_c)); // R5
   AST_CLR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && op == OP_CLR) |=> (!flag_n && flag_z && !flag_v && !flag_c)); // R6
   AST_ASR_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && op == OP_ASR) |=> flag_v == (flag_n ^ flag_c)); // R7
   AST_NO_WRITE_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (op inside {OP_LOAD, OP_KEEP}) |=> $stable({flag_n, flag_z, flag_v, flag_c})); // R8

   if (TRUE_BORROW) begin : g_borrow_check
      AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_wr && op == OP_SUB) |=> flag_c == ($past(op_b) > $past(op_a))); // R3
   end

endmodule

// File: tb/test_nzvc_alu.sv
`timescale 1ns/1ps
module test_nzvc_alu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] op_a = 8'h00;
   logic [7:0] op_b = 8'h00;
   logic [2:0] op_sel = 3'd0;
   logic       flag_en = 1'b0;
   logic [7:0] result;
   logic       flag_n, flag_z, flag_v, flag_c;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int exp_flags = 0;   // {n,z,v,c}

   always #5 clk = ~clk;

   nzvc_alu #(.WIDTH(8), .TRUE_BORROW(1'b1)) i_nzvc_alu (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
      .flag_en(flag_en), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int sgn(int x);
      return (x >= 128) ? x - 256 : x;
   endfunction

   // reference: returns {result[7:0], n, z, v, c} packed as result*16 + flags
   function automatic int model(int a, int b, int op);
      int r, n, z, v, c, m, s, d;
      v = 0; c = 0;
      case (op)
         0: begin d = a + b; r = d % 256; c = (d > 255);
                  v = (sgn(a) + sgn(b) > 127 || sgn(a) + sgn(b) < -128); end
         1, 2, 3, 4: begin
            m = (op == 1 || op == 3) ? a : 0;
            s = (op == 1) ? b : (op == 2) ? a : 0;
            r = (m - s + 256) % 256; c = (s > m);
            v = (sgn(m) - sgn(s) > 127 || sgn(m) - sgn(s) < -128); end
         5: begin r = (a / 2) + (a >= 128 ? 128 : 0); c = a % 2;
                  v = ((r >= 128) ? 1 : 0) ^ c; end
         6: r = b;
         default: r = a;
      endcase
      n = (r >= 128); z = (r == 0);
      return r * 16 + n * 8 + z * 4 + v * 2 + c;
   endfunction

   task automatic run_op(int a, int b, int op, bit en, string tag);
      int m;
      m = model(a, b, op);
      @(negedge clk);
      op_a = a[7:0]; op_b = b[7:0]; op_sel = op[2:0]; flag_en = en;
      #1;
      check(tag, "result", int'(result), m / 16);
      if (en && op < 6) exp_flags = m % 16;
      @(negedge clk);
      check((en && op < 6) ? "R1" : tag, "nz", int'({flag_n, flag_z}), exp_flags / 4);
      check(tag, "vc", int'({flag_v, flag_c}), exp_flags % 4);
      flag_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R10: flags zero while and after reset
      repeat (2) @(negedge clk);
      check("R10", "flags in reset", int'({flag_n, flag_z, flag_v, flag_c}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "flags after reset", int'({flag_n, flag_z, flag_v, flag_c}), 0);

      // R2 worked vectors
      run_op('h7A, 'h52, 0, 1, "R2");
      check("R2", "7A+52 flags", exp_flags, 4'b1010);
      run_op('h2A, 'h52, 0, 1, "R2");
      run_op('hAC, 'h8A, 0, 1, "R2");
      run_op('hAC, 'h72, 0, 1, "R2");
      run_op('h80, 'h80, 0, 1, "R2");
      run_op('hFF, 'h01, 0, 1, "R2");
      // R3 worked vectors
      run_op('h7A, 'h5C, 1, 1, "R3");
      run_op('h8A, 'h5C, 1, 1, "R3");
      run_op('h5C, 'h8A, 1, 1, "R3");
      check("R3", "5C-8A flags", exp_flags, 4'b1011);
      run_op('h2C, 'h72, 1, 1, "R3");
      run_op('h80, 'h01, 1, 1, "R3");
      run_op('h00, 'h01, 1, 1, "R3");

      // single-operand sweeps
      for (int a = 0; a < 256; a++) run_op(a, 'h5A, 2, 1, "R4");
      for (int a = 0; a < 256; a++) run_op(a, 'hA5, 3, 1, "R5");
      for (int a = 0; a < 256; a++) run_op(a, 'h33, 5, 1, "R7");
      run_op('hFF, 'h00, 0, 1, "R2");
      run_op('h91, 'h17, 4, 1, "R6");
      check("R6", "clear pattern", exp_flags, 4'b0100);

      // two-operand grid
      for (int a = 0; a < 256; a++)
         for (int b = 0; b < 256; b += 5) begin
            run_op(a, b, 0, 1, "R2");
            run_op(a, b, 1, 1, "R3");
         end

      // R8: load and keep leave flags even with enable high
      run_op('h5C, 'h8A, 1, 1, "R3");
      run_op('h00, 'h00, 6, 1, "R8");
      run_op('h00, 'h80, 6, 1, "R8");
      run_op('h00, 'h11, 7, 1, "R8");
      run_op('h80, 'h11, 7, 1, "R8");

      // R9: enable low, flag-affecting ops
      run_op('h00, 'h00, 4, 1, "R6");
      for (int i = 0; i < 64; i++)
         run_op(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                int'($urandom_range(0, 5)), 0, "R9");

      // R10: reset in mid-run
      run_op('hAC, 'h8A, 0, 1, "R2");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10", "flags cleared by reset", int'({flag_n, flag_z, flag_v, flag_c}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      exp_flags = 0;
      run_op('h01, 'h01, 1, 1, "R3");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule